// File: doc/BRIEF.md
# Programmable I2C Waveform Sequencer

This block drives the clock and data lines of an I2C bus from a table of step entries. Software fills the table, then starts execution. There is no fixed protocol state machine. Each entry states, for one time step, the level of each line and whether the data line is sampled. It also holds a run flag and the index of the entry that follows. Chains of entries form start conditions, bit slots, bytes and stop conditions. Software builds these chains from whatever order of operations the transfer needs.

After reset the table holds 1024 entries, each a self-loop whose run flag is clear. The block writes these entries itself, one per cycle. Software then writes entries through a single 32-bit word port, and each word carries its own target index. A start pulse begins execution at a chosen entry, and `busy` stays high until the engine reaches an entry whose run flag is clear. Each step holds the line levels for a fixed number of clock cycles, set by a parameter. Bits sampled on read steps are shifted into a data register, which software reads once `busy` has fallen.

Both line outputs follow an open-drain convention. A 1 means the line is released and may float high. A 0 means the pad pulls the line low.

Top module: `i2c_wave_seq`

## Requirements
- R1: After reset the block writes every table entry, one per cycle, as a self-loop with the run flag clear and both lines released. `busy` is high during this fill and falls after exactly 1024 clock edges. A table write or a start pulse that arrives during the fill is ignored.
- R2: A table word is decoded as follows. Bits 27:18 give the target entry index. Bit 13 is the run flag, bit 12 is sample-enable, bit 11 is the inverted SCL level, bit 10 is the inverted SDA level, and bits 9:0 give the next-entry index.
- R3: A `go` pulse while idle starts execution at `go_addr`, and `busy` is high from the next cycle on. A `go` pulse while a sequence runs has no effect.
- R4: Each entry with the run flag set drives `scl_o` and `sda_o` to its non-inverted levels for exactly STEP_CYC cycles. These levels appear one cycle after the step begins.
- R5: After each step the engine moves to the entry named by the next-entry index. When it reaches an entry with the run flag clear, `busy` falls one cycle later and both lines are released.
- R6: On a step with sample-enable set, `sda_in` is sampled in the last cycle of the step and shifted into `rd_data` at bit 0, older bits moving up. `rd_data` is cleared when a run starts and is held after the run ends.
- R7: A run started at an entry whose run flag is clear keeps `busy` high for one cycle only and leaves both lines released.
- R8: Chained start, write-bit, read-bit, acknowledge and stop entries reproduce their level sequences step for step. The last stop entry links back to entry 0, and that link ends the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_wdata | input | 32 | Table word: target index, step levels, flags and next index |
| go | input | 1 | Start pulse |
| go_addr | input | 10 | Entry where execution begins |
| sda_in | input | 1 | Sensed level of the data line |
| scl_o | output | 1 | Clock line, 1 = released, 0 = pulled low |
| sda_o | output | 1 | Data line, 1 = released, 0 = pulled low |
| busy | output | 1 | High during the table fill and while a sequence runs |
| rd_data | output | RD_W | Sampled read bits, newest bit at bit 0 |

## Verification
Random transfers are placed at random table offsets. Each is a start condition, one to three written bytes with random values, zero to two read bytes and a stop condition. These programs are compared with a cycle-accurate trace model, which separates faults in the level decoding, the step length and the link order. The simulated slave drives random data, then all-ones and all-zeros, and changes its bit on each SCL fall. These patterns expose a wrong sample cycle, a wrong shift direction and stale bits. Directed cases cover several situations. A run starts on an untouched self-loop entry. An entry is cut short by clearing its run flag mid-sequence. A start pulse arrives during a run. A write and a start arrive during the reset fill.

// File: rtl/i2cws_pkg.sv
package i2cws_pkg;
    localparam int unsigned NEXT_W = 10;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned DEPTH  = 1 << NEXT_W;
    localparam int unsigned F_IDX  = 18;
    localparam int unsigned F_RUN  = 13;
    localparam int unsigned F_SMP  = 12;
    localparam int unsigned F_NSCL = 11;
    localparam int unsigned F_NSDA = 10;

    typedef struct packed {
        logic              run;
        logic              smp;
        logic              nscl;
        logic              nsda;
        logic [NEXT_W-1:0] nxt;
    } step_t;

    function automatic step_t word_to_step(input logic [WORD_W-1:0] w);
        step_t s;
        s.run  = w[F_RUN];
        s.smp  = w[F_SMP];
        s.nscl = w[F_NSCL];
        s.nsda = w[F_NSDA];
        s.nxt  = w[NEXT_W-1:0];
        return s;
    endfunction

    function automatic step_t idle_step(input logic [NEXT_W-1:0] self_idx);
        step_t s;
        s.run  = 1'b0;
        s.smp  = 1'b0;
        s.nscl = 1'b0;
        s.nsda = 1'b0;
        s.nxt  = self_idx;
        return s;
    endfunction
endpackage

// File: rtl/wave_table.sv
module wave_table
    import i2cws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [NEXT_W-1:0] host_idx,
    input  step_t             host_step,
    input  logic [NEXT_W-1:0] rd_idx,
    output step_t             rd_step,
    output logic              filling
);
    localparam logic [NEXT_W-1:0] LAST_IDX = {NEXT_W{1'b1}};

    typedef struct packed {
        logic              fill;
        logic [NEXT_W-1:0] idx;
    } fill_t;

    fill_t st_d, st_q;
    step_t mem [DEPTH];

    logic              wr_en;
    logic [NEXT_W-1:0] wr_idx;
    step_t             wr_step;

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_idx  = host_idx;
        wr_step = host_step;
        if (st_q.fill) begin
            wr_en   = 1'b1;
            wr_idx  = st_q.idx;
            wr_step = idle_step(st_q.idx);
            st_d.idx = st_q.idx + 1'b1;
            if (st_q.idx == LAST_IDX) st_d.fill = 1'b0;
        end else if (host_we) begin
            wr_en = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fill <= 1'b1;
            st_q.idx  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_step;
    end

    assign rd_step = mem[rd_idx];
    assign filling = st_q.fill;

    // R1
    fill_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.fill |=> !st_q.fill);

    // R1
    fill_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fill && st_q.idx != LAST_IDX) |=> (st_q.fill && st_q.idx == $past(st_q.idx) + 1'b1));
endmodule

// File: rtl/wave_engine.sv
module wave_engine
    import i2cws_pkg::*;
#(
    parameter int unsigned STEP_CYC = 250,
    parameter int unsigned RD_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              go,
    input  logic [NEXT_W-1:0] go_addr,
    input  step_t             cur,
    input  logic              sda_in,
    output logic [NEXT_W-1:0] pc,
    output logic              scl_o,
    output logic              sda_o,
    output logic              running,
    output logic [RD_W-1:0]   rd_data
);
    localparam int unsigned CNT_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEP_CYC - 1);

    typedef struct packed {
        logic              run;
        logic [NEXT_W-1:0] pc;
        logic [CNT_W-1:0]  cnt;
        logic              scl;
        logic              sda;
        logic [RD_W-1:0]   sh;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            st_d.scl = 1'b1;
            st_d.sda = 1'b1;
            st_d.cnt = '0;
            if (go && !hold) begin
                st_d.run = 1'b1;
                st_d.pc  = go_addr;
                st_d.sh  = '0;
            end
        end else if (!cur.run) begin
            st_d.run = 1'b0;
            st_d.scl = 1'b1;
            st_d.sda = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.scl = ~cur.nscl;
            st_d.sda = ~cur.nsda;
            if (st_q.cnt == LAST_CNT) begin
                st_d.cnt = '0;
                st_d.pc  = cur.nxt;
                if (cur.smp) st_d.sh = {st_q.sh[RD_W-2:0], sda_in};
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.run <= 1'b0;
            st_q.pc  <= '0;
            st_q.cnt <= '0;
            st_q.scl <= 1'b1;
            st_q.sda <= 1'b1;
            st_q.sh  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc      = st_q.pc;
    assign scl_o   = st_q.scl;
    assign sda_o   = st_q.sda;
    assign running = st_q.run;
    assign rd_data = st_q.sh;

    // R5
    lines_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |=> (st_q.scl && st_q.sda));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_CNT);

    // R4
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.cnt != LAST_CNT) |=> $stable(st_q.pc));

    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !(cur.run && cur.smp && st_q.cnt == LAST_CNT)) |=> $stable(st_q.sh));

    // R3
    go_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && go && !hold) |=> st_q.run);
endmodule

// File: rtl/i2c_wave_seq.sv
module i2c_wave_seq
    import i2cws_pkg::*;
#(
    parameter int unsigned STEP_CYC = 250,
    parameter int unsigned RD_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [WORD_W-1:0] tbl_wdata,
    input  logic              go,
    input  logic [NEXT_W-1:0] go_addr,
    input  logic              sda_in,
    output logic              scl_o,
    output logic              sda_o,
    output logic              busy,
    output logic [RD_W-1:0]   rd_data
);
    step_t             cur_step;
    step_t             host_step;
    logic [NEXT_W-1:0] host_idx;
    logic [NEXT_W-1:0] pc;
    logic              filling;
    logic              running;

    assign host_idx  = tbl_wdata[F_IDX +: NEXT_W];
    assign host_step = word_to_step(tbl_wdata);

    wave_table u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (tbl_we),
        .host_idx  (host_idx),
        .host_step (host_step),
        .rd_idx    (pc),
        .rd_step   (cur_step),
        .filling   (filling)
    );

    wave_engine #(
        .STEP_CYC (STEP_CYC),
        .RD_W     (RD_W)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (filling),
        .go      (go),
        .go_addr (go_addr),
        .cur     (cur_step),
        .sda_in  (sda_in),
        .pc      (pc),
        .scl_o   (scl_o),
        .sda_o   (sda_o),
        .running (running),
        .rd_data (rd_data)
    );

    assign busy = filling | running;

    // R1
    fill_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        filling |-> (busy && !running));
endmodule

// File: tb/i2c_wave_seq_test.sv
module i2c_wave_seq_test;
    localparam int S    = 5;
    localparam int RDW  = 32;
    localparam int NSTP = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [31:0] tbl_wdata = '0;
    logic        go = 1'b0;
    logic [9:0]  go_addr = '0;
    logic        sda_in;
    logic        scl_o, sda_o, busy;
    logic [RDW-1:0] rd_data;

    int checks = 0;
    int failures = 0;

    bit  mb [1024];
    bit  mr [1024];
    bit  ms [1024];
    bit  md [1024];
    int  mn [1024];

    bit  es [NSTP];
    bit  ed [NSTP];
    int  nsteps;
    logic [RDW-1:0] erd;

    logic [255:0] slave_pat = '0;
    int fall_cnt = 0;
    int cur = 0;

    always #10 clk = ~clk;

    i2c_wave_seq #(.STEP_CYC(S), .RD_W(RDW)) uut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_wdata(tbl_wdata),
        .go(go), .go_addr(go_addr), .sda_in(sda_in),
        .scl_o(scl_o), .sda_o(sda_o), .busy(busy), .rd_data(rd_data)
    );

    assign sda_in = ((fall_cnt < 256) ? slave_pat[fall_cnt] : 1'b1) & sda_o;
    always @(negedge scl_o) fall_cnt = fall_cnt + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R2: word layout index[27:18] run[13] sample[12] ~scl[11] ~sda[10] next[9:0]
    task automatic put(input int a, input bit run, input bit smp, input bit scl, input bit sda, input int nxt);
        @(negedge clk);
        tbl_we = 1'b1;
        tbl_wdata = (32'(a) << 18) | (32'(run) << 13) | (32'(smp) << 12) |
                    (32'(!scl) << 11) | (32'(!sda) << 10) | (32'(nxt) & 32'h3ff);
        mb[a] = run; mr[a] = smp; ms[a] = scl; md[a] = sda; mn[a] = nxt;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic emit(input bit scl, input bit sda, input bit smp);
        put(cur, 1'b1, smp, scl, sda, cur + 1);
        cur++;
    endtask

    task automatic seq_start();
        emit(1, 1, 0); emit(1, 0, 0); emit(0, 0, 0);
    endtask

    task automatic seq_wbit(input bit b);
        emit(0, b, 0); emit(1, b, 0); emit(0, b, 0);
    endtask

    task automatic seq_wbyte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) seq_wbit(v[i]);
        seq_wbit(1'b1);
    endtask

    task automatic seq_rbyte(input bit last);
        for (int i = 0; i < 8; i++) begin
            emit(0, 1, 0); emit(1, 1, 0); emit(1, 1, 1); emit(0, 1, 0);
        end
        seq_wbit(last);
    endtask

    task automatic seq_stop();
        emit(0, 0, 0); emit(1, 0, 0);
        put(cur, 1'b1, 1'b0, 1'b1, 1'b1, 0);
        cur++;
    endtask

    task automatic model_run(input int start);
        int a = start;
        bit prev = 1'b1;
        int falls = 0;
        nsteps = 0;
        erd = '0;
        while (mb[a] && nsteps < NSTP) begin
            es[nsteps] = ms[a];
            ed[nsteps] = md[a];
            if (prev && !ms[a]) falls++;
            prev = ms[a];
            if (mr[a]) erd = {erd[RDW-2:0], slave_pat[falls] & md[a]};
            a = mn[a];
            nsteps++;
        end
    endtask

    task automatic do_run(input int start, input bit inject);
        model_run(start);
        fall_cnt = 0;
        @(negedge clk);
        go = 1'b1;
        go_addr = 10'(start);
        @(negedge clk);
        go = 1'b0;
        chk(busy === 1'b1, "R3 busy after go", 32'(busy), 32'd1);
        for (int c = 1; c <= nsteps * S; c++) begin
            @(negedge clk);
            go = 1'b0;
            chk(scl_o === es[(c-1)/S], "R4 R8 scl step level", 32'(scl_o), 32'(es[(c-1)/S]));
            chk(sda_o === ed[(c-1)/S], "R2 R4 sda step level", 32'(sda_o), 32'(ed[(c-1)/S]));
            chk(busy === 1'b1, "R3 busy during run", 32'(busy), 32'd1);
            if (inject && c == 7) begin
                go = 1'b1;
                go_addr = 10'd0;
            end
        end
        @(negedge clk);
        chk(busy === 1'b0, "R5 busy falls at end", 32'(busy), 32'd0);
        chk(scl_o === 1'b1 && sda_o === 1'b1, "R5 lines released at end", {30'd0, scl_o, sda_o}, 32'd3);
        chk(rd_data === erd, "R6 read data", rd_data, erd);
        repeat (3) @(negedge clk);
        chk(rd_data === erd, "R6 read data held", rd_data, erd);
    endtask

    task automatic rand_prog(input bit inject);
        int base = 1 + int'($urandom % 600);
        int nw   = 1 + int'($urandom % 3);
        int nr   = int'($urandom % 3);
        cur = base;
        seq_start();
        for (int i = 0; i < nw; i++) seq_wbyte(8'($urandom));
        for (int i = 0; i < nr; i++) seq_rbyte(i == nr - 1);
        seq_stop();
        do_run(base, inject);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin : main
        int n;
        void'($urandom(32'd4711));
        for (int i = 0; i < 1024; i++) begin
            mb[i] = 0; mr[i] = 0; ms[i] = 1; md[i] = 1; mn[i] = i;
        end
        repeat (3) @(negedge clk);
        chk(scl_o === 1'b1 && sda_o === 1'b1, "R1 lines released in reset", {30'd0, scl_o, sda_o}, 32'd3);
        rst_n = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 500) begin
                // R1: write and go during the fill are ignored
                tbl_we = 1'b1;
                tbl_wdata = (32'd100 << 18) | (32'd1 << 13) | (32'd1 << 11) | 32'd101;
                go = 1'b1;
                go_addr = 10'd100;
            end else begin
                tbl_we = 1'b0;
                go = 1'b0;
            end
        end while (busy === 1'b1 && n < 3000);
        chk(n == 1024, "R1 fill length", 32'(n), 32'd1024);
        repeat (2) @(negedge clk);
        chk(busy === 1'b0, "R1 go during fill ignored", 32'(busy), 32'd0);

        // R7 / R1: untouched entries are idle self-loops
        do_run(100, 1'b0);
        do_run(777, 1'b0);
        chk(nsteps == 0, "R7 idle entry gives zero steps", 32'(nsteps), 32'd0);

        slave_pat = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        rand_prog(1'b1);  // R3: go injected mid-run
        for (int k = 0; k < 4; k++) begin
            slave_pat = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            rand_prog(1'b0);
        end
        slave_pat = '1;
        rand_prog(1'b0);
        slave_pat = '0;
        rand_prog(1'b0);

        // R5: clearing the run flag mid-sequence ends the run there
        slave_pat = {8{32'ha5c3_0f96}};
        cur = 800;
        seq_start();
        seq_rbyte(1'b0);
        seq_stop();
        put(815, 1'b0, 1'b0, 1'b0, 1'b0, 815);
        do_run(800, 1'b0);
        chk(nsteps == 15, "R5 early end step count", 32'(nsteps), 32'd15);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule